// File: doc/BRIEF.md
# Microsequenced Multiply-Add-Store Pipeline

This block evaluates short multiply-then-add recipes on one shared multiplier and one shared adder, and writes each result into a small register bank. A program table holds up to eight steps. Each step word chooses the multiplier operands, the adder operands and the destination bank entry. A start pulse runs steps 0 through a chosen last index. One step is issued per clock with no stalls.

All of a step's choices are issued together in the issue cycle. The adder selects then travel one register further down the pipe, and the destination select travels two registers further, so each choice arrives at its own stage. Either multiplier operand can be replaced by the product of the step issued just before, which builds chained powers in consecutive steps. The adder can add the previous step's sum, which gives accumulation. The bank is read back combinationally through an address port.

Operands are sampled at fixed points in the pipe:
- The multiplier inputs are sampled at the clock edge that ends the issue cycle.
- The adder inputs are sampled at the clock edge that ends the following cycle.
- Each result is written at the clock edge that ends the second cycle after issue.

Top module: `mas_pipe`

## Requirements
- R1: The active-low asynchronous reset clears the following to zero: all bank entries, `busy_o`, `done_o`, the product available as feedback, and the previous sum.
- R2: When `busy_o` is low, a high `prog_we_i` at a clock edge stores `prog_data_i` into program entry `prog_addr_i`. While `busy_o` is high, program writes are ignored.
- R3: A step word is laid out as follows:
  - bit 6: multiplier operand A source (0 = `mul_a_i`, 1 = low 11 bits of the feedback product).
  - bit 5: multiplier operand B source (0 = `mul_b_i`, 1 = low 3 bits of the feedback product).
  - bit 4: adder operand A source (0 = product, 1 = `add_c_i`).
  - bits 3:2: adder operand B source (0 = `add_c_i`, 1 = `add_d_i`, 2 = zero, 3 = previous sum).
  - bits 1:0: destination bank entry.
- R4: A start pulse that is sampled while `busy_o` is low launches the program. Steps 0 through `last_idx_i` are then issued, one per cycle, starting in the next cycle. `busy_o` is high in exactly those issue cycles. A start pulse sampled while `busy_o` is high is ignored.
- R5: The multiplier produces the full 14-bit unsigned product of its two registered operands.
- R6: The feedback product is the product of the step issued most recently. This holds across separate runs.
- R7: The adder zero-extends its operands to 19 bits, adds them, and drops any carry out of bit 18. The previous-sum operand is the result of the step issued most recently.
- R8: A step's result is written to its destination entry at the clock edge that ends the second cycle after its issue cycle. No other entry changes at that edge.
- R9: `done_o` is high for exactly one cycle, two cycles after the last step of a run is issued.
- R10: `rd_data_o` shows bank entry `rd_addr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_we_i | input | 1 | Program entry write enable |
| prog_addr_i | input | 3 | Program entry index |
| prog_data_i | input | 7 | Step word to store |
| start_i | input | 1 | Launch the program |
| last_idx_i | input | 3 | Index of the last step to run |
| mul_a_i | input | 11 | External multiplier operand A |
| mul_b_i | input | 3 | External multiplier operand B |
| add_c_i | input | 19 | External adder operand C |
| add_d_i | input | 19 | External adder operand D |
| rd_addr_i | input | 2 | Bank read index |
| rd_data_o | output | 19 | Bank entry contents |
| busy_o | output | 1 | Steps being issued |
| done_o | output | 1 | Run completion pulse |

## Verification
Each kind of internal fault shows up differently at the ports:
- A misaligned control delay line routes a result to the wrong bank entry, or pairs it with the wrong adder operand. Either error becomes visible on the read port one cycle after `done_o`.
- A stale or cleared feedback product corrupts every later entry of a power chain. The corruption also carries into the first step of the next run.
- A sequencer that miscounts moves the fall of `busy_o` and the `done_o` pulse by whole cycles, which the cycle-exact checks catch during the run itself.

// File: rtl/mas_pkg.sv
package mas_pkg;
  typedef enum logic {
    MUL_SRC_EXT = 1'b0,
    MUL_SRC_FB  = 1'b1
  } mul_src_e;

  typedef enum logic {
    ADDA_PROD = 1'b0,
    ADDA_EXT  = 1'b1
  } add_a_src_e;

  typedef enum logic [1:0] {
    ADDB_C    = 2'd0,
    ADDB_D    = 2'd1,
    ADDB_ZERO = 2'd2,
    ADDB_PREV = 2'd3
  } add_b_src_e;
endpackage

// File: rtl/mas_seq.sv
module mas_seq #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned WORD_W = 7,
  localparam int unsigned PA_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_we_i,
  input  logic [PA_W-1:0]   prog_addr_i,
  input  logic [WORD_W-1:0] prog_data_i,
  input  logic              start_i,
  input  logic [PA_W-1:0]   last_idx_i,
  output logic              issue_o,
  output logic              issue_last_o,
  output logic [WORD_W-1:0] word_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [WORD_W-1:0] table_w [DEPTH];
  logic              busy_q;
  logic [PA_W-1:0]   pc_q, last_q;
  logic [1:0]        done_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_prog
    logic [WORD_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                              ent_q <= '0;
      else if (prog_we_i && !busy_q && prog_addr_i == PA_W'(g)) ent_q <= prog_data_i;
    end
    assign table_w[g] = ent_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pc_q   <= '0;
      last_q <= '0;
    end else if (busy_q) begin
      if (pc_q == last_q) busy_q <= 1'b0;
      else                pc_q   <= pc_q + PA_W'(1);
    end else if (start_i) begin
      busy_q <= 1'b1;
      pc_q   <= '0;
      last_q <= last_idx_i;
    end
  end

  assign issue_o      = busy_q;
  assign issue_last_o = busy_q && (pc_q == last_q);
  assign word_o       = table_w[pc_q];
  assign busy_o       = busy_q;

  // completion travels with the last step's write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= '0;
    else         done_q <= {done_q[0], issue_last_o};
  end
  assign done_o = done_q[1];
endmodule

// File: rtl/mas_dp.sv
module mas_dp
  import mas_pkg::*;
#(
  parameter int unsigned A_W    = 11,
  parameter int unsigned B_W    = 3,
  parameter int unsigned ACC_W  = 19,
  parameter int unsigned DEST_W = 2,
  localparam int unsigned P_W   = A_W + B_W,
  localparam int unsigned WORD_W = 5 + DEST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [A_W-1:0]    mul_a_i,
  input  logic [B_W-1:0]    mul_b_i,
  input  logic [ACC_W-1:0]  add_c_i,
  input  logic [ACC_W-1:0]  add_d_i,
  output logic              wr_en_o,
  output logic [DEST_W-1:0] wr_idx_o,
  output logic [ACC_W-1:0]  wr_data_o,
  output logic [A_W-1:0]    mul_a_q_o,
  output logic [P_W-1:0]    product_o
);
  mul_src_e    sel_ma, sel_mb;
  add_a_src_e  sel_aa;
  add_b_src_e  sel_ab;

  assign sel_ma = mul_src_e'(word_i[DEST_W+4]);
  assign sel_mb = mul_src_e'(word_i[DEST_W+3]);
  assign sel_aa = add_a_src_e'(word_i[DEST_W+2]);
  assign sel_ab = add_b_src_e'(word_i[DEST_W+1:DEST_W]);

  // stage 1: multiplier operands plus delayed adder/dest selects
  logic [A_W-1:0]    mul_a_q;
  logic [B_W-1:0]    mul_b_q;
  logic              v1_q;
  add_a_src_e        aa1_q;
  add_b_src_e        ab1_q;
  logic [DEST_W-1:0] dst1_q;
  logic [P_W-1:0]    product;

  assign product = P_W'(mul_a_q) * P_W'(mul_b_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mul_a_q <= '0;
      mul_b_q <= '0;
      v1_q    <= 1'b0;
      aa1_q   <= ADDA_PROD;
      ab1_q   <= ADDB_C;
      dst1_q  <= '0;
    end else begin
      v1_q <= issue_i;
      if (issue_i) begin
        mul_a_q <= (sel_ma == MUL_SRC_FB) ? product[A_W-1:0] : mul_a_i;
        mul_b_q <= (sel_mb == MUL_SRC_FB) ? product[B_W-1:0] : mul_b_i;
        aa1_q   <= sel_aa;
        ab1_q   <= sel_ab;
        dst1_q  <= word_i[DEST_W-1:0];
      end
    end
  end

  // stage 2: adder operands plus dest select delayed once more
  logic [ACC_W-1:0]  add_a_q, add_b_q, sum;
  logic              v2_q;
  logic [DEST_W-1:0] dst2_q;
  logic [ACC_W-1:0]  nxt_a, nxt_b;

  assign sum = add_a_q + add_b_q;

  always_comb begin
    nxt_a = (aa1_q == ADDA_EXT) ? add_c_i : ACC_W'(product);
    unique case (ab1_q)
      ADDB_C:    nxt_b = add_c_i;
      ADDB_D:    nxt_b = add_d_i;
      ADDB_ZERO: nxt_b = '0;
      default:   nxt_b = sum;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      add_a_q <= '0;
      add_b_q <= '0;
      v2_q    <= 1'b0;
      dst2_q  <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        add_a_q <= nxt_a;
        add_b_q <= nxt_b;
        dst2_q  <= dst1_q;
      end
    end
  end

  assign wr_en_o   = v2_q;
  assign wr_idx_o  = dst2_q;
  assign wr_data_o = sum;
  assign mul_a_q_o = mul_a_q;
  assign product_o = product;
endmodule

// File: rtl/mas_bank.sv
module mas_bank #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned W       = 19,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [W-1:0]     data_i,
  input  logic [IDX_W-1:0] rd_addr_i,
  output logic [W-1:0]     rd_data_o
);
  logic [W-1:0] ent_w [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              val_q <= '0;
      else if (we_i && idx_i == IDX_W'(g))      val_q <= data_i;
    end
    assign ent_w[g] = val_q;
  end

  assign rd_data_o = ent_w[rd_addr_i];
endmodule

// File: rtl/mas_pipe.sv
module mas_pipe #(
  parameter int unsigned MUL_A_W    = 11,
  parameter int unsigned MUL_B_W    = 3,
  parameter int unsigned ACC_W      = 19,
  parameter int unsigned NUM_REGS   = 4,
  parameter int unsigned PROG_DEPTH = 8,
  localparam int unsigned DEST_W    = $clog2(NUM_REGS),
  localparam int unsigned PA_W      = $clog2(PROG_DEPTH),
  localparam int unsigned WORD_W    = 5 + DEST_W,
  localparam int unsigned P_W       = MUL_A_W + MUL_B_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_we_i,
  input  logic [PA_W-1:0]   prog_addr_i,
  input  logic [WORD_W-1:0] prog_data_i,
  input  logic              start_i,
  input  logic [PA_W-1:0]   last_idx_i,
  input  logic [MUL_A_W-1:0] mul_a_i,
  input  logic [MUL_B_W-1:0] mul_b_i,
  input  logic [ACC_W-1:0]  add_c_i,
  input  logic [ACC_W-1:0]  add_d_i,
  input  logic [DEST_W-1:0] rd_addr_i,
  output logic [ACC_W-1:0]  rd_data_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              issue, issue_last;
  logic [WORD_W-1:0] word;
  logic              wr_en;
  logic [DEST_W-1:0] wr_idx;
  logic [ACC_W-1:0]  wr_data;
  logic [MUL_A_W-1:0] mul_a_q;
  logic [P_W-1:0]    product;

  mas_seq #(.DEPTH(PROG_DEPTH), .WORD_W(WORD_W)) u_seq (
    .clk_i, .rst_ni, .prog_we_i, .prog_addr_i, .prog_data_i,
    .start_i, .last_idx_i,
    .issue_o(issue), .issue_last_o(issue_last), .word_o(word),
    .busy_o, .done_o
  );

  mas_dp #(.A_W(MUL_A_W), .B_W(MUL_B_W), .ACC_W(ACC_W), .DEST_W(DEST_W)) u_dp (
    .clk_i, .rst_ni, .issue_i(issue), .word_i(word),
    .mul_a_i, .mul_b_i, .add_c_i, .add_d_i,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .mul_a_q_o(mul_a_q), .product_o(product)
  );

  mas_bank #(.ENTRIES(NUM_REGS), .W(ACC_W)) u_bank (
    .clk_i, .rst_ni, .we_i(wr_en), .idx_i(wr_idx), .data_i(wr_data),
    .rd_addr_i, .rd_data_o
  );
endmodule

// File: rtl/mas_pipe_chk.sv
module mas_pipe_chk #(
  parameter int unsigned A_W    = 11,
  parameter int unsigned P_W    = 14,
  parameter int unsigned ACC_W  = 19,
  parameter int unsigned DEST_W = 2,
  parameter int unsigned WORD_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              issue,
  input logic              issue_last,
  input logic [WORD_W-1:0] word,
  input logic              wr_en,
  input logic [DEST_W-1:0] rd_addr_i,
  input logic [ACC_W-1:0]  rd_data_o,
  input logic [A_W-1:0]    mul_a_q,
  input logic [P_W-1:0]    product
);
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_last |-> ##2 done_o);  // R9
  AST_DONE_ONLY_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(issue_last, 2));  // R9
  AST_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !issue_last) |=> busy_o);  // R4
  AST_BUSY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_last |=> !busy_o);  // R4
  AST_WRITE_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> $past(issue, 2));  // R8
  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> (!$stable(rd_addr_i) || $stable(rd_data_o)));  // R10
  AST_FEEDBACK_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && word[WORD_W-1]) |=> (mul_a_q == $past(product[A_W-1:0])));  // R6
endmodule

bind mas_pipe mas_pipe_chk #(
  .A_W(MUL_A_W), .P_W(P_W), .ACC_W(ACC_W), .DEST_W(DEST_W), .WORD_W(WORD_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .issue(issue), .issue_last(issue_last), .word(word), .wr_en(wr_en),
  .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .mul_a_q(mul_a_q), .product(product)
);

// File: tb/mas_pipe_tb.sv
module mas_pipe_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prog_we_i = 1'b0;
  logic [2:0]  prog_addr_i = '0;
  logic [6:0]  prog_data_i = '0;
  logic        start_i = 1'b0;
  logic [2:0]  last_idx_i = '0;
  logic [10:0] mul_a_i = '0;
  logic [2:0]  mul_b_i = '0;
  logic [18:0] add_c_i = '0;
  logic [18:0] add_d_i = '0;
  logic [1:0]  rd_addr_i = '0;
  logic [18:0] rd_data_o;
  logic        busy_o, done_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic [13:0] m_prod = '0;
  logic [18:0] m_sum = '0;
  logic [18:0] m_bank [4];
  logic [6:0]  m_prog [8];

  mas_pipe u_dut (.*);

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      checks++;
      failures++;
      $display("FAIL R4 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic [6:0] w);
    @(negedge clk_i);
    prog_we_i = 1'b1; prog_addr_i = 3'(idx); prog_data_i = w;
    @(negedge clk_i);
    prog_we_i = 1'b0;
    m_prog[idx] = w;
  endtask

  task automatic model_run(input int last);
    for (int s = 0; s <= last; s++) begin
      logic [6:0]  w;
      logic [10:0] ma;
      logic [2:0]  mb;
      logic [13:0] p;
      logic [18:0] aa, bb;
      w  = m_prog[s];
      ma = w[6] ? m_prod[10:0] : mul_a_i;
      mb = w[5] ? m_prod[2:0]  : mul_b_i;
      p  = 14'(ma) * 14'(mb);
      aa = w[4] ? add_c_i : 19'(p);
      case (w[3:2])
        2'd0: bb = add_c_i;
        2'd1: bb = add_d_i;
        2'd2: bb = '0;
        default: bb = m_sum;
      endcase
      m_sum  = aa + bb;
      m_prod = p;
      m_bank[w[1:0]] = m_sum;
    end
  endtask

  task automatic check_bank(input string tag);
    for (int r = 0; r < 4; r++) begin
      rd_addr_i = 2'(r);
      #1;
      chk($sformatf("R8 R10 %s bank[%0d]", tag, r), 32'(rd_data_o), 32'(m_bank[r]));
    end
  endtask

  task automatic run(input int last, input string tag, input bit poke);
    @(negedge clk_i);
    last_idx_i = 3'(last);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i <= last + 2; i++) begin
      chk($sformatf("R4 %s busy cycle %0d", tag, i), 32'(busy_o), 32'(i <= last));
      chk($sformatf("R9 %s done cycle %0d", tag, i), 32'(done_o), 32'(i == last + 2));
      if (poke && i == 0) begin
        start_i = 1'b1; prog_we_i = 1'b1; prog_addr_i = 3'd0; prog_data_i = ~m_prog[0];
      end
      if (poke && i == 1) begin
        start_i = 1'b0; prog_we_i = 1'b0;
      end
      if (i != last + 2) @(negedge clk_i);
    end
    @(negedge clk_i);
    model_run(last);
    check_bank(tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_0123));
    for (int r = 0; r < 4; r++) m_bank[r] = '0;
    for (int s = 0; s < 8; s++) m_prog[s] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 busy after reset", 32'(busy_o), 32'd0);
    chk("R1 done after reset", 32'(done_o), 32'd0);
    check_bank("R1 reset");

    // R1 R6 feedback is zero after reset: 0*b + d into entry 2
    mul_a_i = 11'd9; mul_b_i = 3'd5; add_c_i = 19'd0; add_d_i = 19'd5;
    load(0, 7'b1_0_0_01_10);
    run(0, "R1 R6 zero feedback", 1'b0);

    // R6 R3 chained powers of 3 into entries 0..3
    mul_a_i = 11'd1; mul_b_i = 3'd3;
    load(0, 7'b0_0_0_10_00);
    load(1, 7'b1_0_0_10_01);
    load(2, 7'b1_0_0_10_10);
    load(3, 7'b1_0_0_10_11);
    run(3, "R6 powers", 1'b0);
    chk("R6 third power", 32'(m_bank[2]), 32'd27);

    // R7 carry out of 19 bits is dropped
    add_c_i = 19'h7FFFF; add_d_i = 19'h7FFFF;
    load(0, 7'b0_0_1_01_11);
    run(0, "R7 carry drop", 1'b0);
    chk("R7 wrap value", 32'(m_bank[3]), 32'h7FFFE);

    // R5 R7 max product plus c, then B feedback with accumulate
    mul_a_i = 11'h7FF; mul_b_i = 3'd7; add_c_i = 19'd100; add_d_i = 19'd3;
    load(0, 7'b0_0_0_00_00);
    load(1, 7'b0_1_0_11_01);
    run(1, "R5 R7 accumulate", 1'b0);

    // R2 R4 start and program write during busy are ignored
    mul_a_i = 11'd21; mul_b_i = 3'd2; add_c_i = 19'd1; add_d_i = 19'd2;
    load(0, 7'b0_0_0_01_10);
    run(0, "R2 R4 poke", 1'b1);
    run(0, "R2 rerun", 1'b0);

    // R5 R6 R7 random programs
    for (int n = 0; n < 40; n++) begin
      int last;
      last = int'($urandom_range(0, 7));
      for (int s = 0; s <= last; s++) load(s, 7'($urandom));
      mul_a_i = 11'($urandom); mul_b_i = 3'($urandom);
      add_c_i = 19'($urandom); add_d_i = 19'($urandom);
      run(last, "R5 R7 random", 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule